// File: doc/BRIEF.md
# Bit Field Extract and Insert Unit

This unit works on 36-bit accumulator values. It either pulls a bit field out of a source word and right-justifies it, or writes the low bits of a source word into a field of a destination word. A single 16-bit control word describes the field. Its high byte gives the field width in bits. Its low byte gives the position of the field's lowest bit. The control word comes either from an immediate carried with the request or from one of four auxiliary control registers. Those registers are loaded through a plain write port.

Requests arrive on a valid/ready channel. The unit works on one request at a time. `req_ready` is high only while the unit is idle, so a request stays pending until the unit is free. The operation completes in one or two cycles, depending on the operation and on where the control word comes from.

Results leave on a valid/ready channel. While `res_valid` is high and `res_ready` is low, the result is held unchanged. The unit returns to idle on the cycle after the result handshake.

Top module: `bitfield_unit`

## Requirements
- R1: The field width is bits 15:8 of the control word and the field offset is bits 7:0. The control word is `req_imm` when `req_use_aux` is 0, and auxiliary register `req_aux_sel` when it is 1.
- R2: With `req_insert`=0 and `req_signed`=1, the result holds source bits [offset+width-1:offset] in its low bits. Every bit above the field equals the field's top bit.
- R3: With `req_insert`=0 and `req_signed`=0, the result holds the same right-justified field, and every bit above it is 0.
- R4: With `req_insert`=1, the low `width` bits of `req_src` replace destination bits [offset+width-1:offset]. Every other bit of `req_dst` passes to the result unchanged.
- R5: A width of 0 gives a result of 0 for extraction and a result equal to `req_dst` for insertion.
- R6: Field bits at positions above 35 are dropped. For extraction the effective field top is then bit 35, which also supplies the sign. An offset of 36 or more gives an empty field.
- R7: Counted from the accepting clock edge, `res_valid` rises 1 edge later for extraction with an auxiliary control word, and 2 edges later for extraction with an immediate and for any insertion.
- R8: `req_ready` is high exactly when the unit is idle. A result is held stable with `res_valid` high until it is taken with `res_ready`. The unit is idle again on the cycle after that handshake.
- R9: When `aux_wr_en` is high, auxiliary register `aux_wr_sel` takes `aux_wr_data` at the clock edge. A request accepted on that same edge uses the register's previous value.
- R10: After reset, `req_ready` is 1, `res_valid` is 0, and all auxiliary registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aux_wr_en | input | 1 | Write strobe for the auxiliary control registers |
| aux_wr_sel | input | 2 | Auxiliary register to write |
| aux_wr_data | input | 16 | Control word to write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_insert | input | 1 | 1 selects insertion, 0 selects extraction |
| req_signed | input | 1 | For extraction: 1 fills with the sign, 0 fills with zeros |
| req_use_aux | input | 1 | 1 takes the control word from an auxiliary register |
| req_aux_sel | input | 2 | Auxiliary register read by the request |
| req_imm | input | 16 | Immediate control word |
| req_src | input | 36 | Extraction source, or insertion field data |
| req_dst | input | 36 | Insertion destination |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 36 | Result accumulator value |

## Verification
The hardest case to reach from the ports is an auxiliary register being rewritten on the very edge that a request reading it is accepted. The request must then see the old word, and the next request must see the new one. The bench lines up a register write and an auxiliary-sourced request on the same negative edge. It checks both values, and it also lets random writes land on accept edges throughout a long random run. Clipped fields are reached by choosing offsets near and beyond bit 35 with oversized widths. Back-pressure is reached by holding `res_ready` low across several cycles, both in a directed test and at random.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } bfu_state_e;

  typedef struct packed {
    logic ins;
    logic sgn;
  } bfu_mode_t;

endpackage

// File: rtl/bfu_aux_regs.sv
module bfu_aux_regs #(
  parameter int NUM   = 4,
  parameter int WIDTH = 16,
  localparam int SEL_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] regs_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(g))) begin
        regs_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = regs_q[rd_sel];

endmodule

// File: rtl/bfu_field_mask.sv
module bfu_field_mask #(
  parameter int ACC_W = 36,
  parameter int CNT_W = 9
) (
  input  logic [CNT_W-1:0] eff_width,
  output logic [ACC_W-1:0] low_mask,
  output logic [ACC_W-1:0] top_bit
);

  for (genvar i = 0; i < ACC_W; i++) begin : g_bit
    assign low_mask[i] = (eff_width > CNT_W'(i));
    assign top_bit[i]  = (eff_width == CNT_W'(i + 1));
  end

endmodule

// File: rtl/bfu_field_core.sv
module bfu_field_core
  import bfu_pkg::*;
#(
  parameter int ACC_W = 36,
  parameter int CTL_W = 16
) (
  input  bfu_mode_t        mode,
  input  logic [CTL_W-1:0] ctl,
  input  logic [ACC_W-1:0] src,
  input  logic [ACC_W-1:0] dst,
  output logic [ACC_W-1:0] result
);

  localparam int FW   = CTL_W / 2;
  localparam int CW   = FW + 1;
  localparam logic [CW-1:0] ACC_CW = CW'(ACC_W);

  logic [FW-1:0]    fld_w;
  logic [FW-1:0]    fld_o;
  logic [CW-1:0]    room;
  logic [CW-1:0]    eff_w;
  logic [ACC_W-1:0] low_mask;
  logic [ACC_W-1:0] top_bit;
  logic [ACC_W-1:0] shifted;
  logic             sign_bit;
  logic [ACC_W-1:0] ext_val;
  logic [ACC_W-1:0] place_mask;
  logic [ACC_W-1:0] ins_val;

  assign fld_w = ctl[CTL_W-1 -: FW];
  assign fld_o = ctl[FW-1:0];

  // Clip the field so that it never reaches past the top accumulator bit.
  assign room  = ({1'b0, fld_o} >= ACC_CW) ? '0 : (ACC_CW - {1'b0, fld_o});
  assign eff_w = ({1'b0, fld_w} < room) ? {1'b0, fld_w} : room;

  bfu_field_mask #(
    .ACC_W (ACC_W),
    .CNT_W (CW)
  ) u_mask (
    .eff_width (eff_w),
    .low_mask  (low_mask),
    .top_bit   (top_bit)
  );

  assign shifted  = src >> fld_o;
  assign sign_bit = |(shifted & top_bit);
  assign ext_val  = (shifted & low_mask) | ({ACC_W{mode.sgn & sign_bit}} & ~low_mask);

  assign place_mask = low_mask << fld_o;
  assign ins_val    = (dst & ~place_mask) | ((src << fld_o) & place_mask);

  assign result = mode.ins ? ins_val : ext_val;

endmodule

// File: rtl/bfu_seq.sv
module bfu_seq
  import bfu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic short_op,
  input  logic res_ready,
  output logic req_ready,
  output logic in_wait,
  output logic res_valid,
  output logic load_res
);

  bfu_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) state_d = short_op ? ST_HOLD : ST_WAIT;
      ST_WAIT: state_d = ST_HOLD;
      ST_HOLD: if (res_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign in_wait   = (state_q == ST_WAIT);
  assign res_valid = (state_q == ST_HOLD);
  assign load_res  = in_wait || (req_ready && req_valid && short_op);

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
#(
  parameter int ACC_W   = 36,
  parameter int CTL_W   = 16,
  parameter int NUM_AUX = 4,
  localparam int SEL_W  = (NUM_AUX > 1) ? $clog2(NUM_AUX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aux_wr_en,
  input  logic [SEL_W-1:0] aux_wr_sel,
  input  logic [CTL_W-1:0] aux_wr_data,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_insert,
  input  logic             req_signed,
  input  logic             req_use_aux,
  input  logic [SEL_W-1:0] req_aux_sel,
  input  logic [CTL_W-1:0] req_imm,
  input  logic [ACC_W-1:0] req_src,
  input  logic [ACC_W-1:0] req_dst,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [ACC_W-1:0] res_data
);

  logic [CTL_W-1:0] aux_word;
  logic [CTL_W-1:0] live_ctl;
  logic             accept;
  logic             short_op;
  logic             in_wait;
  logic             load_res;
  bfu_mode_t        live_mode, held_mode, core_mode;
  logic [CTL_W-1:0] held_ctl, core_ctl;
  logic [ACC_W-1:0] held_src, held_dst, core_src, core_dst;
  logic [ACC_W-1:0] core_res;
  logic [ACC_W-1:0] res_q;

  bfu_aux_regs #(
    .NUM   (NUM_AUX),
    .WIDTH (CTL_W)
  ) u_aux (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (aux_wr_en),
    .wr_sel  (aux_wr_sel),
    .wr_data (aux_wr_data),
    .rd_sel  (req_aux_sel),
    .rd_data (aux_word)
  );

  assign live_ctl      = req_use_aux ? aux_word : req_imm;
  assign live_mode.ins = req_insert;
  assign live_mode.sgn = req_signed;
  assign short_op      = !req_insert && req_use_aux;
  assign accept        = req_valid && req_ready;

  bfu_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .short_op  (short_op),
    .res_ready (res_ready),
    .req_ready (req_ready),
    .in_wait   (in_wait),
    .res_valid (res_valid),
    .load_res  (load_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_mode <= '0;
      held_ctl  <= '0;
      held_src  <= '0;
      held_dst  <= '0;
    end else if (accept) begin
      held_mode <= live_mode;
      held_ctl  <= live_ctl;
      held_src  <= req_src;
      held_dst  <= req_dst;
    end
  end

  assign core_mode = in_wait ? held_mode : live_mode;
  assign core_ctl  = in_wait ? held_ctl  : live_ctl;
  assign core_src  = in_wait ? held_src  : req_src;
  assign core_dst  = in_wait ? held_dst  : req_dst;

  bfu_field_core #(
    .ACC_W (ACC_W),
    .CTL_W (CTL_W)
  ) u_core (
    .mode   (core_mode),
    .ctl    (core_ctl),
    .src    (core_src),
    .dst    (core_dst),
    .result (core_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        res_q <= '0;
    else if (load_res) res_q <= core_res;
  end

  assign res_data = res_q;

endmodule

// File: rtl/bfu_chk.sv
module bfu_chk #(
  parameter int ACC_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_insert,
  input logic             req_use_aux,
  input logic             res_valid,
  input logic             res_ready,
  input logic [ACC_W-1:0] res_data
);

  // R8: a result left untaken stays put
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R8: no acceptance while a result is pending
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  // R8: a result only disappears after a handshake
  a_r8_drop_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(res_valid) |-> $past(res_ready));

  // R7: short extraction completes after one edge
  a_r7_short_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_insert && req_use_aux) |=> res_valid);

  // R7: other operations complete after two edges
  a_r7_long_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_insert || !req_use_aux)) |=> (!res_valid ##1 res_valid));

endmodule

bind bitfield_unit bfu_chk #(.ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_insert  (req_insert),
  .req_use_aux (req_use_aux),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_data    (res_data)
);

// File: tb/tb_bitfield_unit.sv
`timescale 1ns/1ps
module tb_bitfield_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        aux_wr_en = 1'b0;
  logic [1:0]  aux_wr_sel = '0;
  logic [15:0] aux_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_insert = 1'b0;
  logic        req_signed = 1'b0;
  logic        req_use_aux = 1'b0;
  logic [1:0]  req_aux_sel = '0;
  logic [15:0] req_imm = '0;
  logic [35:0] req_src = '0;
  logic [35:0] req_dst = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [35:0] res_data;

  always #2 clk = ~clk;

  bitfield_unit dut (
    .clk(clk), .rst_n(rst_n),
    .aux_wr_en(aux_wr_en), .aux_wr_sel(aux_wr_sel), .aux_wr_data(aux_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_insert(req_insert),
    .req_signed(req_signed), .req_use_aux(req_use_aux), .req_aux_sel(req_aux_sel),
    .req_imm(req_imm), .req_src(req_src), .req_dst(req_dst),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  string cur_req = "R10";

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Behavioural reference: walks the field bit by bit.
  function automatic logic [35:0] ref_op(logic ins, logic sgn, logic [15:0] c,
                                         logic [35:0] s, logic [35:0] d);
    int w = c[15:8];
    int o = c[7:0];
    int n = 0;
    logic [35:0] r = ins ? d : 36'd0;
    for (int i = 0; i < 36; i++) begin
      if (i >= o && i < o + w) begin
        if (ins) r[i] = s[i-o];
        else begin r[i-o] = s[i]; n = i - o + 1; end
      end
    end
    if (!ins && sgn && n > 0)
      for (int i = n; i < 36; i++) r[i] = r[n-1];
    return r;
  endfunction

  // Cycle model: 0 idle, 1 waiting, 2 holding a result
  int          m_state = 0;
  logic [35:0] m_data = '0;
  logic [35:0] m_pend = '0;
  logic [15:0] m_aux [4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0;
      for (int i = 0; i < 4; i++) m_aux[i] = '0;
    end else begin
      case (m_state)
        0: if (req_valid) begin
          logic [15:0] c;
          logic [35:0] r;
          c = req_use_aux ? m_aux[req_aux_sel] : req_imm;
          r = ref_op(req_insert, req_signed, c, req_src, req_dst);
          if (!req_insert && req_use_aux) begin m_state = 2; m_data = r; end
          else begin m_state = 1; m_pend = r; end
        end
        1: begin m_state = 2; m_data = m_pend; end
        default: if (res_ready) m_state = 0;
      endcase
      if (aux_wr_en) m_aux[aux_wr_sel] = aux_wr_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_req, "/R8 ready"}, {35'd0, req_ready}, {35'd0, m_state == 0});
      chk({cur_req, "/R7 valid"}, {35'd0, res_valid}, {35'd0, m_state == 2});
      if (res_valid && m_state == 2) chk({cur_req, " data"}, res_data, m_data);
    end
  end

  task automatic aux_write(logic [1:0] sel, logic [15:0] val);
    @(negedge clk);
    aux_wr_en = 1; aux_wr_sel = sel; aux_wr_data = val;
    @(negedge clk);
    aux_wr_en = 0;
  endtask

  task automatic do_op(logic ins, logic sgn, logic use_aux, logic [1:0] sel,
                       logic [15:0] imm, logic [35:0] s, logic [35:0] d,
                       logic wr, logic [1:0] wsel, logic [15:0] wval,
                       output logic [35:0] res, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_insert = ins; req_signed = sgn; req_use_aux = use_aux;
    req_aux_sel = sel; req_imm = imm; req_src = s; req_dst = d;
    aux_wr_en = wr; aux_wr_sel = wsel; aux_wr_data = wval;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    req_valid = 0; aux_wr_en = 0;
    while (!res_valid) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    res = res_data;
  endtask

  logic [35:0] r;
  int          lat;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 ready", {35'd0, req_ready}, 36'd1);
    chk("R10 valid", {35'd0, res_valid}, 36'd0);
    do_op(0, 0, 1, 2'd3, 16'h0000, 36'hFFFFFFFFF, 0, 0, 0, 0, r, lat);
    chk("R10 aux zero", r, 36'd0);

    cur_req = "R2";
    do_op(0, 1, 0, 0, 16'h0404, 36'h0000000A5, 0, 0, 0, 0, r, lat);
    chk("R2 sign fill", r, 36'hFFFFFFFFA);
    chk("R7 imm extract latency", lat, 2);
    cur_req = "R3";
    do_op(0, 0, 0, 0, 16'h0404, 36'h0000000A5, 0, 0, 0, 0, r, lat);
    chk("R3 zero fill", r, 36'h00000000A);

    cur_req = "R4";
    do_op(1, 0, 0, 0, 16'h0808, 36'h12345675A, 36'hFFFFFFFFF, 0, 0, 0, r, lat);
    chk("R4 insert", r, 36'hFFFFF5AFF);
    chk("R7 imm insert latency", lat, 2);

    cur_req = "R1";
    aux_write(2'd2, 16'h0C10);
    do_op(0, 0, 1, 2'd2, 16'h0000, 36'h0ABCDEF12, 0, 0, 0, 0, r, lat);
    chk("R1 aux control", r, 36'h000000BCD);
    chk("R7 aux extract latency", lat, 1);
    do_op(1, 0, 1, 2'd2, 16'h0000, 36'h000000FFF, 36'h0, 0, 0, 0, r, lat);
    chk("R1 aux insert", r, 36'h00FFF0000);
    chk("R7 aux insert latency", lat, 2);

    cur_req = "R5";
    do_op(0, 1, 0, 0, 16'h0005, 36'hFFFFFFFFF, 0, 0, 0, 0, r, lat);
    chk("R5 zero width extract", r, 36'd0);
    do_op(1, 0, 0, 0, 16'h0003, 36'hFFFFFFFFF, 36'h123456789, 0, 0, 0, r, lat);
    chk("R5 zero width insert", r, 36'h123456789);

    cur_req = "R6";
    do_op(0, 1, 0, 0, 16'h0820, 36'hA00000000, 0, 0, 0, 0, r, lat);
    chk("R6 clipped sign", r, 36'hFFFFFFFFA);
    do_op(1, 0, 0, 0, 16'h0820, 36'h0000000FF, 36'h0, 0, 0, 0, r, lat);
    chk("R6 clipped insert", r, 36'hF00000000);
    do_op(0, 0, 0, 0, 16'h0824, 36'hFFFFFFFFF, 0, 0, 0, 0, r, lat);
    chk("R6 offset past top", r, 36'd0);

    cur_req = "R9";
    aux_write(2'd0, 16'h0404);
    do_op(0, 0, 1, 2'd0, 0, 36'h0000000A5, 0, 1, 2'd0, 16'h0800, r, lat);
    chk("R9 old word on write edge", r, 36'h00000000A);
    do_op(0, 0, 1, 2'd0, 0, 36'h0000000A5, 0, 0, 0, 0, r, lat);
    chk("R9 new word after write", r, 36'h0000000A5);

    cur_req = "R8";
    @(negedge clk);
    res_ready = 0;
    do_op(0, 0, 0, 0, 16'h1000, 36'h00000BEEF, 0, 0, 0, 0, r, lat);
    repeat (4) begin
      @(negedge clk);
      chk("R8 held data", res_data, 36'h00000BEEF);
      chk("R8 held valid", {35'd0, res_valid}, 36'd1);
    end
    res_ready = 1;
    @(negedge clk);
    chk("R8 idle after take", {35'd0, req_ready}, 36'd1);

    cur_req = "R7 random";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      req_valid   = ($urandom_range(0, 3) != 0);
      req_insert  = $urandom_range(0, 1);
      req_signed  = $urandom_range(0, 1);
      req_use_aux = $urandom_range(0, 1);
      req_aux_sel = 2'($urandom_range(0, 3));
      req_imm     = {8'($urandom_range(0, 40)), 8'($urandom_range(0, 40))};
      if ($urandom_range(0, 15) == 0) req_imm[15:8] = 8'hFF;
      req_src     = {4'($urandom), 32'($urandom)};
      req_dst     = {4'($urandom), 32'($urandom)};
      aux_wr_en   = ($urandom_range(0, 3) == 0);
      aux_wr_sel  = 2'($urandom_range(0, 3));
      aux_wr_data = {8'($urandom_range(0, 40)), 8'($urandom_range(0, 40))};
      res_ready   = ($urandom_range(0, 2) != 0);
    end
    @(negedge clk);
    req_valid = 0; aux_wr_en = 0; res_ready = 1;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule